// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block drives a serial EEPROM that stores 16-bit words and talks over a chip-select, clock, data-in and data-out wire set. A client presents one command at a time (read, single-word write, block write, write-enable or write-disable), together with an address, a write word and, for reads, a word count. The controller builds the bit frame, generates the serial clock from the system clock, shifts the frame out MSB first and, on reads, collects the returned words and hands each one back with a one-cycle valid strobe.

All serial timing is derived from the system clock frequency. The serial clock's high and low phases, the chip-select low gap and the chip-select setup ahead of the first clock are set by parameters. After a write or block write, the controller ends the frame between the last data clock and the next one so that the device commits the data. It then re-selects the device with the clock held low and the data line at 0, and watches the data-out wire until the device reports ready. If ready never comes within a parameterised window, the command ends with a timeout flag.

Top module: `mw_host`

## Requirements
- R1: While reset is held and whenever the controller is idle (busy low), ee_cs and ee_sk are low. Directly after reset, ee_di, busy and done are also low.
- R2: Each frame begins with a 1, followed by a 2-bit opcode and an AW-bit address field, MSB first. Commands are encoded on req_cmd as READ=0 (opcode 10), WRITE=1 (opcode 01), WRAL=2 (opcode 00, address field 01 followed by the block bits taken from req_addr[AW-3:0]), WEN=3 (opcode 00, address field 11 followed by zeros) and WDS=4 (opcode 00, address field all zeros). WEN and WDS frames carry exactly 3+AW serial clock rises (11 by default). WRITE and WRAL frames append the 16 data bits, for 3+AW+16 rises (27 by default).
- R3: Every serial clock high phase and every low phase inside a frame lasts at least HALF_CYC system clocks, where HALF_CYC is the smallest count covering 250 ns (13 at 50 MHz). ee_di changes only while ee_sk is low.
- R4: ee_cs stays low for at least GAP_CYC system clocks, the smallest count covering 200 ns (10 at 50 MHz), before every rise. ee_cs is high for at least HALF_CYC clocks before the first ee_sk rise of a frame. ee_sk is high only while ee_cs is high.
- R5: On READ, the bit presented with the last address clock is a dummy and is dropped. Each following group of 16 bits is assembled MSB first and delivered on rd_data with a one-cycle rd_valid pulse. req_len words are returned from consecutive addresses in one frame (req_len 0 counts as 1), so the frame has 3+AW+16×words rises.
- R6: A WRITE or WRAL frame is ended by lowering ee_cs, with ee_sk low, after the high phase of the clock that carries data bit 0 and before any further rise.
- R7: After a WRITE or WRAL frame, ee_cs is raised again after the gap with no ee_sk rise and ee_di at 0. ee_do is watched until it reads 1, and only then does ee_cs fall and the command complete. The command therefore lasts longer than the device's busy time.
- R8: If ee_do has not read 1 within POLL_CYC system clocks of the poll start (POLL_CYC = CLK_KHZ×TOUT_US/1000), the poll ends, ee_cs falls and err_timeout pulses together with done.
- R9: done pulses for exactly one cycle at the end of every command, and busy is high from acceptance until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request, taken when busy is low |
| req_cmd | input | 3 | Command code (see R2) |
| req_addr | input | AW | Word address, or block number for WRAL |
| req_wdata | input | 16 | Word to write (WRITE, WRAL) |
| req_len | input | LENW | Number of words for READ (0 means 1) |
| busy | output | 1 | Command in progress |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | 16 | Word returned by a read |
| done | output | 1 | One-cycle pulse at command end |
| err_timeout | output | 1 | Pulses with done when the ready poll expired |
| ee_cs | output | 1 | Device select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data and ready status from the device |

## Verification
The hardest case to reach from the ports is the poll timeout, because a healthy device always reports ready. The bench's behavioural device has a stuck-busy input that keeps the status low through a whole poll. The bench shortens the window parameter so that the expiry falls within the run, and it checks that the command still completes with the error pulse and a dropped select. The commit boundary between data bit 0 and the next clock is checked through the device model itself: the model discards any write whose frame saw an extra rise. Read-after-write results, including bursts that wrap past the top address and blocks written in one command, expose any framing error.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_WRAL  = 3'd2,
        CMD_WEN   = 3'd3,
        CMD_WDS   = 3'd4
    } mw_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_POLL
    } mw_st_e;

    localparam int unsigned WORD_W = 16;
endpackage

// File: rtl/mw_delay.sv
// Loadable down-counter; done while the count rests at zero.
module mw_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= value;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/mw_frame.sv
// Builds the left-aligned outgoing bit pattern and the number of clock rises.
module mw_frame
    import mw_pkg::*;
#(
    parameter int AW   = 8,
    parameter int LENW = 4,
    parameter int FW   = 3 + AW + 16,
    parameter int CW   = 10
) (
    input  logic [2:0]      cmd,
    input  logic [AW-1:0]   addr,
    input  logic [15:0]     wdata,
    input  logic [LENW-1:0] len,
    output logic [FW-1:0]   frame,
    output logic [CW-1:0]   total,
    output logic            is_rd,
    output logic            needs_poll
);
    localparam int NHDR = 3 + AW;

    logic [1:0]      op;
    logic [AW-1:0]   afield;
    logic [15:0]     dfield;
    logic [LENW-1:0] nwords;

    always_comb begin
        op         = 2'b00;
        afield     = '0;
        dfield     = '0;
        is_rd      = 1'b0;
        needs_poll = 1'b0;
        nwords     = (len == '0) ? LENW'(1) : len;
        total      = CW'(NHDR);
        case (mw_cmd_e'(cmd))
            CMD_READ: begin
                op     = 2'b10;
                afield = addr;
                is_rd  = 1'b1;
                total  = CW'(NHDR) + (CW'(nwords) << 4);
            end
            CMD_WRITE: begin
                op         = 2'b01;
                afield     = addr;
                dfield     = wdata;
                needs_poll = 1'b1;
                total      = CW'(FW);
            end
            CMD_WRAL: begin
                afield     = {2'b01, addr[AW-3:0]};
                dfield     = wdata;
                needs_poll = 1'b1;
                total      = CW'(FW);
            end
            CMD_WEN: begin
                afield = {2'b11, {(AW-2){1'b0}}};
            end
            default: begin
                afield = '0;
            end
        endcase
        frame = {1'b1, op, afield, dfield};
    end
endmodule

// File: rtl/mw_host.sv
module mw_host
    import mw_pkg::*;
#(
    parameter int AW      = 8,
    parameter int LENW    = 4,
    parameter int CLK_KHZ = 50000,
    parameter int TOUT_US = 10500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_cmd,
    input  logic [AW-1:0]   req_addr,
    input  logic [15:0]     req_wdata,
    input  logic [LENW-1:0] req_len,
    output logic            busy,
    output logic            rd_valid,
    output logic [15:0]     rd_data,
    output logic            done,
    output logic            err_timeout,
    output logic            ee_cs,
    output logic            ee_sk,
    output logic            ee_di,
    input  logic            ee_do
);
    localparam int HALF_CYC = (CLK_KHZ * 250 + 999999) / 1000000;
    localparam int GAP_CYC  = (CLK_KHZ * 200 + 999999) / 1000000;
    localparam int MAXD     = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
    localparam int TW       = $clog2(MAXD + 1);
    localparam int POLL_CYC = CLK_KHZ * TOUT_US / 1000;
    localparam int PW       = $clog2(POLL_CYC + 1);
    localparam int NHDR     = 3 + AW;
    localparam int FW       = NHDR + 16;
    localparam int CW       = $clog2(NHDR + 16 * (2 ** LENW) + 1);

    typedef struct packed {
        mw_st_e          st;
        logic            cs;
        logic            sk;
        logic            di;
        logic [FW-1:0]   shreg;
        logic [CW-1:0]   rises;
        logic [CW-1:0]   total;
        logic            is_rd;
        logic            poll;
        logic            to;
        logic [3:0]      nbit;
        logic [15:0]     rx;
        logic [15:0]     rdata;
        logic            rd_valid;
        logic            done;
        logic            err;
    } state_t;

    state_t s_d, s_q;

    logic [FW-1:0] fb_frame;
    logic [CW-1:0] fb_total;
    logic          fb_rd, fb_poll;
    logic          t_load, t_done, p_load, p_done;
    logic [TW-1:0] t_val;

    mw_frame #(.AW(AW), .LENW(LENW), .FW(FW), .CW(CW)) i_frame (
        .cmd(req_cmd), .addr(req_addr), .wdata(req_wdata), .len(req_len),
        .frame(fb_frame), .total(fb_total), .is_rd(fb_rd), .needs_poll(fb_poll)
    );

    mw_delay #(.W(TW)) i_phase (
        .clk(clk), .rst_n(rst_n), .load(t_load), .value(t_val), .done(t_done)
    );

    mw_delay #(.W(PW)) i_poll (
        .clk(clk), .rst_n(rst_n), .load(p_load), .value(PW'(POLL_CYC)), .done(p_done)
    );

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        s_d.done     = 1'b0;
        s_d.err      = 1'b0;
        t_load       = 1'b0;
        t_val        = TW'(HALF_CYC - 1);
        p_load       = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st    = ST_LOW;
                    s_d.cs    = 1'b1;
                    s_d.sk    = 1'b0;
                    s_d.shreg = fb_frame;
                    s_d.di    = fb_frame[FW-1];
                    s_d.rises = '0;
                    s_d.total = fb_total;
                    s_d.is_rd = fb_rd;
                    s_d.poll  = fb_poll;
                    s_d.to    = 1'b0;
                    s_d.nbit  = '0;
                    t_load    = 1'b1;
                end
            end
            ST_LOW: begin
                if (t_done) begin
                    // the rise just past carried a data bit (the dummy is rise NHDR)
                    if (s_q.is_rd && (s_q.rises > CW'(NHDR))) begin
                        s_d.rx   = {s_q.rx[14:0], ee_do};
                        s_d.nbit = s_q.nbit + 4'd1;
                        if (s_q.nbit == 4'd15) begin
                            s_d.rd_valid = 1'b1;
                            s_d.rdata    = {s_q.rx[14:0], ee_do};
                        end
                    end
                    t_load = 1'b1;
                    if (s_q.rises == s_q.total) begin
                        s_d.st = ST_GAP;
                        s_d.cs = 1'b0;
                        s_d.di = 1'b0;
                        t_val  = TW'(GAP_CYC - 1);
                    end else begin
                        s_d.st    = ST_HIGH;
                        s_d.sk    = 1'b1;
                        s_d.rises = s_q.rises + 1'b1;
                    end
                end
            end
            ST_HIGH: begin
                if (t_done) begin
                    s_d.sk    = 1'b0;
                    s_d.shreg = {s_q.shreg[FW-2:0], 1'b0};
                    s_d.di    = s_q.shreg[FW-2];
                    t_load    = 1'b1;
                    if (!s_q.is_rd && (s_q.rises == s_q.total)) begin
                        // drop select between the last data clock and the next one
                        s_d.st = ST_GAP;
                        s_d.cs = 1'b0;
                        s_d.di = 1'b0;
                        t_val  = TW'(GAP_CYC - 1);
                    end else begin
                        s_d.st = ST_LOW;
                    end
                end
            end
            ST_GAP: begin
                if (t_done) begin
                    if (s_q.poll) begin
                        s_d.st = ST_POLL;
                        s_d.cs = 1'b1;
                        s_d.di = 1'b0;
                        t_load = 1'b1;
                        t_val  = TW'(GAP_CYC - 1);
                        p_load = 1'b1;
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.err  = s_q.to;
                        s_d.to   = 1'b0;
                    end
                end
            end
            ST_POLL: begin
                if ((t_done && ee_do) || p_done) begin
                    s_d.st   = ST_GAP;
                    s_d.cs   = 1'b0;
                    s_d.poll = 1'b0;
                    s_d.to   = !(t_done && ee_do);
                    t_load   = 1'b1;
                    t_val    = TW'(GAP_CYC - 1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.st != ST_IDLE);
    assign rd_valid    = s_q.rd_valid;
    assign rd_data     = s_q.rdata;
    assign done        = s_q.done;
    assign err_timeout = s_q.err;
    assign ee_cs       = s_q.cs;
    assign ee_sk       = s_q.sk;
    assign ee_di       = s_q.di;
endmodule

// File: rtl/mw_host_chk.sv
module mw_host_chk #(
    parameter int CLK_KHZ = 50000
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic rd_valid,
    input logic done,
    input logic err_timeout,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);
    localparam int HALF_CYC = (CLK_KHZ * 250 + 999999) / 1000000;
    localparam int GAP_CYC  = (CLK_KHZ * 200 + 999999) / 1000000;

    logic [15:0] sk_hi_n, sk_lo_n, cs_lo_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_hi_n <= '0;
            sk_lo_n <= 16'(HALF_CYC);
            cs_lo_n <= 16'(GAP_CYC);
        end else begin
            sk_hi_n <= ee_sk ? sk_hi_n + 16'd1 : 16'd0;
            if (ee_sk)                        sk_lo_n <= 16'd0;
            else if (sk_lo_n < 16'(HALF_CYC)) sk_lo_n <= sk_lo_n + 16'd1;
            if (ee_cs)                        cs_lo_n <= 16'd0;
            else if (cs_lo_n < 16'(GAP_CYC))  cs_lo_n <= cs_lo_n + 16'd1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_cs && !ee_sk));
    assert_di_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
    assert_sk_high_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sk) |-> (sk_hi_n >= 16'(HALF_CYC)));
    assert_sk_low_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> (sk_lo_n >= 16'(HALF_CYC)));
    assert_sk_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);
    assert_cs_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (cs_lo_n >= 16'(GAP_CYC)));
    assert_rdv_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> done);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_cs_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ee_cs);
endmodule

bind mw_host mw_host_chk #(.CLK_KHZ(CLK_KHZ)) i_mw_host_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid), .done(done),
    .err_timeout(err_timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/mw_eeprom_model.sv
// Behavioural serial EEPROM used as the bench's device.
module mw_eeprom_model #(
    parameter int AW       = 8,
    parameter int BUSY_CYC = 300
) (
    input  logic clk,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic stuck,
    output logic do_o
);
    logic [15:0]   mem [0:(1<<AW)-1];
    logic [1:0]    op;
    logic [AW-1:0] adr;
    logic [15:0]   dat, word;
    bit            we_en, started, armed, stat_en, rd_on, rd_bit, cs_prev;
    int            cnt, idx, tick, busy_end;

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 16'hFFFF;
        we_en = 0; started = 0; armed = 0; stat_en = 0; rd_on = 0; rd_bit = 0;
        cs_prev = 0; cnt = 0; idx = 15; busy_end = 0; op = 0; adr = 0; dat = 0; word = 0;
    end

    initial tick = 0;
    always @(posedge clk) tick <= tick + 1;

    assign do_o = cs && (stat_en ? (!stuck && (tick >= busy_end)) : rd_bit);

    always @(posedge sk or posedge cs or negedge cs) begin
        if (cs != cs_prev) begin
            cs_prev = cs;
            if (cs) begin
                started = 0; cnt = 0; rd_on = 0; rd_bit = 0; armed = 0;
            end else if (armed) begin
                armed = 0;
                stat_en = 1;
                if (we_en) begin
                    if (op == 2'b01) mem[adr] = dat;
                    else begin
                        for (int i = 0; i < 128; i++)
                            mem[(int'(adr[AW-3:0]) % (1 << (AW-7))) * 128 + i] = dat;
                    end
                    busy_end = tick + BUSY_CYC;
                end
            end
        end else if (cs) begin
            if (!started) begin
                if (di) begin started = 1; cnt = 0; stat_en = 0; end
            end else begin
                cnt++;
                armed = 0;
                if (cnt <= 2) op = {op[0], di};
                else if (cnt <= 2 + AW) adr = {adr[AW-2:0], di};
                else if (cnt <= 2 + AW + 16) dat = {dat[14:0], di};
                if (cnt == 2 + AW) begin
                    if (op == 2'b10) begin
                        rd_on = 1; rd_bit = 0; word = mem[adr]; idx = 15;
                    end else if (op == 2'b00 && adr[AW-1:AW-2] == 2'b11) we_en = 1;
                    else if (op == 2'b00 && adr[AW-1:AW-2] == 2'b00) we_en = 0;
                end else if (cnt > 2 + AW && rd_on) begin
                    rd_bit = word[idx];
                    if (idx == 0) begin adr = adr + 1'b1; word = mem[adr]; idx = 15; end
                    else idx--;
                end
                if (cnt == 2 + AW + 16 &&
                    (op == 2'b01 || (op == 2'b00 && adr[AW-1:AW-2] == 2'b01)))
                    armed = 1;
            end
        end
    end
endmodule

// File: tb/test_mw_host.sv
module test_mw_host;
    localparam int AW = 8, LENW = 4, CLK_KHZ = 50000, TOUT_US = 20, BUSY_CYC = 300;
    localparam int HALF = 13, GAP = 10, POLL_CYC = 1000;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            req_valid = 1'b0;
    logic [2:0]      req_cmd = '0;
    logic [AW-1:0]   req_addr = '0;
    logic [15:0]     req_wdata = '0;
    logic [LENW-1:0] req_len = '0;
    logic busy, rd_valid, done, err_timeout, ee_cs, ee_sk, ee_di, ee_do;
    logic [15:0] rd_data;
    logic stuck = 1'b0;

    mw_host #(.AW(AW), .LENW(LENW), .CLK_KHZ(CLK_KHZ), .TOUT_US(TOUT_US)) i_mw_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err_timeout(err_timeout),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    mw_eeprom_model #(.AW(AW), .BUSY_CYC(BUSY_CYC)) i_model (
        .clk(clk), .cs(ee_cs), .sk(ee_sk), .di(ee_di), .stuck(stuck), .do_o(ee_do)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard
    logic [15:0] exp_q[$];
    logic [15:0] sh [0:(1<<AW)-1];
    bit sh_we = 0;
    int done_cnt = 0;

    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) check(0, "R5", "unexpected read word", rd_data, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R5", "read word", rd_data, e);
            end
        end
        if (done) done_cnt++;
    end

    // pin monitor
    int hi_len = 0, lo_len = 0, min_hi = 999, min_lo = 999, lo_gap = 1000, min_gap = 999;
    int su_cnt = 0, min_su = 999, rises = 0;
    int di_hi_viol = 0, poll_di_viol = 0, fall_sk_viol = 0;
    bit di_seen = 0;
    logic psk = 0, pcs = 0, pdi = 0;
    int frame_q[$];

    always @(negedge clk) begin
        if (pcs && !ee_cs) begin
            frame_q.push_back(rises);
            if (rises == 0 && di_seen) poll_di_viol++;
            if (ee_sk) fall_sk_viol++;
            lo_gap = 0;
        end
        if (!pcs && ee_cs) begin
            if (lo_gap < min_gap) min_gap = lo_gap;
            rises = 0; su_cnt = 0; di_seen = 0; lo_len = 0;
        end
        if (!ee_cs) lo_gap++;
        if (ee_cs && ee_di) di_seen = 1;
        if (ee_cs && !psk && ee_sk) begin
            if (rises > 0 && lo_len < min_lo) min_lo = lo_len;
            rises++;
            if (rises == 1 && su_cnt < min_su) min_su = su_cnt;
            lo_len = 0;
        end
        if (ee_cs && !ee_sk) begin
            if (rises == 0) su_cnt++;
            else lo_len++;
        end
        if (ee_sk) hi_len++;
        else if (psk) begin
            if (hi_len < min_hi) min_hi = hi_len;
            hi_len = 0;
        end
        if (ee_sk && psk && ee_di != pdi) di_hi_viol++;
        psk = ee_sk; pcs = ee_cs; pdi = ee_di;
    end

    int n_cmds = 0;

    task automatic run_cmd(input logic [2:0] c, input logic [AW-1:0] a, input logic [15:0] d,
                           input logic [LENW-1:0] n, output int cyc, output bit err);
        @(negedge clk);
        while (busy) @(negedge clk);
        frame_q.delete();
        if (c == 3'd0) begin
            int w;
            w = (n == 0) ? 1 : int'(n);
            for (int k = 0; k < w; k++) exp_q.push_back(sh[AW'(int'(a) + k)]);
        end
        if (c == 3'd1 && sh_we) sh[a] = d;
        if (c == 3'd2 && sh_we) for (int k = 0; k < 128; k++) sh[int'(a[0]) * 128 + k] = d;
        if (c == 3'd3) sh_we = 1;
        if (c == 3'd4) sh_we = 0;
        req_valid = 1; req_cmd = c; req_addr = a; req_wdata = d; req_len = n;
        @(negedge clk);
        req_valid = 0;
        cyc = 1;
        while (!done) begin @(negedge clk); cyc++; end
        err = err_timeout;
        n_cmds++;
        @(negedge clk);
        check(exp_q.size() == 0, "R5", "words outstanding", exp_q.size(), 0);
    endtask

    task automatic check_frames(input string req, input int f0, input int f1, input int nf);
        check(frame_q.size() == nf, req, "frame count", frame_q.size(), nf);
        if (frame_q.size() >= 1) check(frame_q[0] == f0, req, "rises in frame", frame_q[0], f0);
        if (nf == 2 && frame_q.size() >= 2)
            check(frame_q[1] == f1, req, "rises in poll frame", frame_q[1], f1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R9", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int cyc;
        bit err;
        for (int i = 0; i < (1 << AW); i++) sh[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        check(!ee_cs && !ee_sk, "R1", "pins in reset", {ee_cs, ee_sk}, 0);
        rst_n = 1;
        @(negedge clk);
        check({ee_cs, ee_sk, ee_di, busy, done} == 5'b0, "R1", "state after reset",
              {ee_cs, ee_sk, ee_di, busy, done}, 0);

        run_cmd(3'd0, 8'h05, 16'h0, 4'd1, cyc, err);                  // R5 single read
        check_frames("R5", 27, 0, 1);

        run_cmd(3'd3, 8'h00, 16'h0, 4'd0, cyc, err);                  // R2 WEN
        check_frames("R2", 11, 0, 1);

        run_cmd(3'd1, 8'h10, 16'hA5C3, 4'd0, cyc, err);               // R6 R7 write
        check_frames("R6", 27, 0, 2);
        check(cyc > BUSY_CYC, "R7", "write waits for ready", cyc, BUSY_CYC);
        check(err == 0, "R7", "no timeout on ready", err, 0);

        run_cmd(3'd1, 8'h11, 16'h5A3C, 4'd0, cyc, err);
        run_cmd(3'd1, 8'hFF, 16'h0F0F, 4'd0, cyc, err);

        run_cmd(3'd0, 8'h10, 16'h0, 4'd2, cyc, err);                  // R5 burst
        check_frames("R5", 43, 0, 1);
        run_cmd(3'd0, 8'hFF, 16'h0, 4'd2, cyc, err);                  // R5 wrap
        run_cmd(3'd0, 8'h11, 16'h0, 4'd0, cyc, err);                  // R5 len 0
        check_frames("R5", 27, 0, 1);

        run_cmd(3'd2, 8'h01, 16'h1234, 4'd0, cyc, err);               // R2 WRAL block 1
        check_frames("R2", 27, 0, 2);
        run_cmd(3'd0, 8'h7F, 16'h0, 4'd3, cyc, err);

        run_cmd(3'd4, 8'h00, 16'h0, 4'd0, cyc, err);                  // R2 WDS
        check_frames("R2", 11, 0, 1);
        run_cmd(3'd1, 8'h20, 16'hBEEF, 4'd0, cyc, err);
        run_cmd(3'd0, 8'h20, 16'h0, 4'd1, cyc, err);                  // unchanged

        run_cmd(3'd3, 8'h00, 16'h0, 4'd0, cyc, err);
        stuck = 1;
        run_cmd(3'd1, 8'h30, 16'h7777, 4'd0, cyc, err);               // R8 timeout
        check(err == 1, "R8", "timeout flagged", err, 1);
        check(cyc > POLL_CYC, "R8", "poll lasted the window", cyc, POLL_CYC);
        check_frames("R8", 27, 0, 2);
        check(!ee_cs, "R8", "select low after timeout", ee_cs, 0);
        stuck = 0;

        check(min_hi >= HALF, "R3", "min SK high", min_hi, HALF);
        check(min_lo >= HALF, "R3", "min SK low", min_lo, HALF);
        check(di_hi_viol == 0, "R3", "DI moved while SK high", di_hi_viol, 0);
        check(min_gap >= GAP, "R4", "min CS low gap", min_gap, GAP);
        check(min_su >= HALF, "R4", "min CS setup", min_su, HALF);
        check(fall_sk_viol == 0, "R6", "CS fell with SK high", fall_sk_viol, 0);
        check(poll_di_viol == 0, "R7", "DI high during poll", poll_di_viol, 0);
        check(done_cnt == n_cmds, "R9", "done pulses", done_cnt, n_cmds);
        finish_run();
    end
endmodule